// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block gathers 64 interrupt lines into two banks of 32 and drives one interrupt request to a single CPU. Each bank holds four pieces of state. The first is a sticky event word. The second is an enable mask. The third is the live level of the sampled lines. The fourth is a fixed per-bit selector that marks which lines are level-sensitive. A line in edge mode latches an event on its rising edge, and that event stays set until software clears it. A line in level mode never latches. It requests service for as long as its sampled level is high. A bank requests service when any enabled bit has an event or a level-mode line is high. The CPU request is the registered OR of the two banks.

Software uses a small register window of 4 KB with 32-bit registers. It reads the events, mask and levels. It writes the mask. It clears events with write-one-to-clear. Reads are combinational from the current register state. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After synchronous reset, the events, mask and levels of both banks read zero and `irq_out` is low.
- R2: The bank index is ((addr − 0x10) mod 4096) >> 4. Index 0 covers 0x10–0x1F and index 1 covers 0x20–0x2F. Any other index, for example at 0x00 or 0x30, ignores writes and reads zero.
- R3: Within a bank, offset 0x0 reads events and offset 0x4 reads and writes the mask. Offset 0x8 is a clear port that is write-only and reads zero. Offset 0xC reads levels. Every other offset reads zero, and a write to it, including a write to 0xC, changes nothing.
- R4: Input k feeds bank 1 − (k >> 5) at bit k & 31. Inputs 0–31 land in bank 1 and inputs 32–63 land in bank 0.
- R5: A bit of the level register equals the input it maps to as sampled at the previous clock edge.
- R6: A bit that is not level-mode sets its event bit on a rising edge of the sampled input. The event then holds through deassertion and while the line stays high, until it is cleared.
- R7: Level-mode bits never set events. Bank 0 has no level-mode bits. Bank 1 has level-mode bits 20 through 28 (mask 0x1FF00000).
- R8: A write to the clear port clears the event bits where the write data is 1, excluding level-mode bits.
- R9: When a rising edge and a clear hit the same event bit at the same clock edge, the event stays set.
- R10: `irq_out` is registered. It equals, one clock edge later, the OR over both banks of ((events | (levels & level-mode)) & mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Interrupt input lines, bit k is input k |
| addr | input | 12 | Register byte address within the 4 KB window |
| wr_en | input | 1 | Write strobe for the current address and data |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address (combinational) |
| irq_out | output | 1 | Combined interrupt request to the CPU |

## Verification
Levels and events show the inputs one edge after they are sampled, and a mask or clear write is visible on reads right after its edge. `irq_out` lags the register state by one further edge, so it responds two edges after an input change or a write. The bench drives every input at the falling edge and advances its reference model at each rising edge. The model stores the CPU request from the state it held before that edge. The bench compares `irq_out` at the next falling edge, and it compares register reads combinationally in the half cycle in which no edge occurs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANKS      = 2;
    localparam int BANK_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int NUM_IRQ    = BANKS * BANK_W;
    localparam int BSEL_W     = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int SPAN_BYTES = 16;
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(16);

    typedef enum logic [3:0] {
        OFS_EVENTS = 4'h0,
        OFS_MASK   = 4'h4,
        OFS_CLEAR  = 4'h8,
        OFS_LEVELS = 4'hC
    } reg_ofs_e;

    typedef struct packed {
        logic              hit;
        logic [BSEL_W-1:0] bank;
        logic [3:0]        ofs;
    } acc_dec_t;

    // fixed level-sensitive selector of each bank
    function automatic logic [BANK_W-1:0] level_sel(input int b);
        return (b == 1) ? BANK_W'(32'h1FF0_0000) : '0;
    endfunction

    function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_dec_t          d;
        logic [ADDR_W-1:0] rel;
        rel    = a - WIN_BASE;
        d.hit  = (rel < ADDR_W'(BANKS * SPAN_BYTES));
        d.bank = rel[4 +: BSEL_W];
        d.ofs  = a[3:0];
        return d;
    endfunction

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lines,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] ev_q,
    output logic [BANK_W-1:0] mk_q,
    output logic [BANK_W-1:0] lv_q,
    output logic              pend
);

    localparam logic [BANK_W-1:0] LVL_SEL = level_sel(BANK_IDX);

    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] clr_bits;

    always_comb begin
        rise     = lines & ~lv_q & ~LVL_SEL;
        clr_bits = clr_we ? (wdata & ~LVL_SEL) : '0;
        pend     = |((ev_q | (lv_q & LVL_SEL)) & mk_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q <= '0;
            mk_q <= '0;
            lv_q <= '0;
        end else begin
            lv_q <= lines;
            ev_q <= (ev_q & ~clr_bits) | rise;
            if (mask_we) begin
                mk_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr_en,
    input  logic [BANKS-1:0][BANK_W-1:0]  ev_all,
    input  logic [BANKS-1:0][BANK_W-1:0]  mk_all,
    input  logic [BANKS-1:0][BANK_W-1:0]  lv_all,
    output logic [BANKS-1:0]              mask_we,
    output logic [BANKS-1:0]              clr_we,
    output logic [BANK_W-1:0]             rdata
);

    acc_dec_t dec;

    always_comb begin
        dec     = decode_addr(addr);
        mask_we = '0;
        clr_we  = '0;
        rdata   = '0;
        if (dec.hit) begin
            if (wr_en && dec.ofs == OFS_MASK)  mask_we[dec.bank] = 1'b1;
            if (wr_en && dec.ofs == OFS_CLEAR) clr_we[dec.bank]  = 1'b1;
            case (dec.ofs)
                OFS_EVENTS: rdata = ev_all[dec.bank];
                OFS_MASK:   rdata = mk_all[dec.bank];
                OFS_LEVELS: rdata = lv_all[dec.bank];
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [BANK_W-1:0]  wdata,
    output logic [BANK_W-1:0]  rdata,
    output logic               irq_out
);

    logic [BANKS-1:0][BANK_W-1:0] ev_all;
    logic [BANKS-1:0][BANK_W-1:0] mk_all;
    logic [BANKS-1:0][BANK_W-1:0] lv_all;
    logic [BANKS-1:0]             pend;
    logic [BANKS-1:0]             mask_we;
    logic [BANKS-1:0]             clr_we;

    irqc_decode u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .ev_all  (ev_all),
        .mk_all  (mk_all),
        .lv_all  (lv_all),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .rdata   (rdata)
    );

    // low input numbers go to the highest bank
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        irqc_bank #(.BANK_IDX(b)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .lines   (irq_in[(BANKS-1-b)*BANK_W +: BANK_W]),
            .mask_we (mask_we[b]),
            .clr_we  (clr_we[b]),
            .wdata   (wdata),
            .ev_q    (ev_all[b]),
            .mk_q    (mk_all[b]),
            .lv_q    (lv_all[b]),
            .pend    (pend[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= |pend;
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_IRQ-1:0]           irq_in,
    input logic [ADDR_W-1:0]            addr,
    input logic                         wr_en,
    input logic [BANKS-1:0][BANK_W-1:0] ev_all,
    input logic [BANKS-1:0][BANK_W-1:0] mk_all,
    input logic [BANKS-1:0][BANK_W-1:0] lv_all,
    input logic                         irq_out
);

    localparam logic [BANK_W-1:0] SEL0 = level_sel(0);
    localparam logic [BANK_W-1:0] SEL1 = level_sel(1);

    logic want;
    logic bad_idx;
    always_comb begin
        want = |(((ev_all[0] | (lv_all[0] & SEL0)) & mk_all[0]) |
                 ((ev_all[1] | (lv_all[1] & SEL1)) & mk_all[1]));
        bad_idx = (addr < ADDR_W'(16)) || (addr > ADDR_W'(47));
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (ev_all == '0 && mk_all == '0 && lv_all == '0 && !irq_out)); // R1

    AST_BAD_INDEX_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bad_idx) |=> $stable(mk_all)); // R2

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ({lv_all[1], lv_all[0]} == $past({irq_in[31:0], irq_in[63:32]}))); // R5

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((ev_all & $past(ev_all)) == $past(ev_all))); // R6

    AST_LEVEL_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (ev_all[1] & SEL1) == '0); // R7

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_out == $past(want))); // R10

endmodule

bind dual_irq_ctrl irqc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .addr    (addr),
    .wr_en   (wr_en),
    .ev_all  (ev_all),
    .mk_all  (mk_all),
    .lv_all  (lv_all),
    .irq_out (irq_out)
);

// File: tb/tb_dual_irq_ctrl.sv
module tb_dual_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_ev [2];
    logic [31:0] m_mk [2];
    logic [31:0] m_lv [2];
    logic        m_irq;

    always #5 clk = ~clk;

    dual_irq_ctrl dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] lsel(input int b);
        return (b == 1) ? 32'h1FF0_0000 : 32'h0;
    endfunction

    function automatic int bank_of(input logic [11:0] a);
        logic [11:0] rel;
        rel = a - 12'h010;
        return (rel[11:4] < 2) ? int'(rel[11:4]) : -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int b;
        b = bank_of(a);
        if (b < 0) return 32'h0;
        case (a[3:0])
            4'h0:    return m_ev[b];
            4'h4:    return m_mk[b];
            4'hC:    return m_lv[b];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_edge();
        logic p;
        p = 1'b0;
        for (int b = 0; b < 2; b++) begin
            logic [31:0] nb, rise, clr;
            p  = p | (|((m_ev[b] | (m_lv[b] & lsel(b))) & m_mk[b]));
            nb = (b == 0) ? irq_in[63:32] : irq_in[31:0];
            rise = nb & ~m_lv[b] & ~lsel(b);
            clr  = '0;
            if (wr_en && bank_of(addr) == b) begin
                if (addr[3:0] == 4'h4) m_mk[b] = wdata;
                if (addr[3:0] == 4'h8) clr = wdata & ~lsel(b);
            end
            m_ev[b] = (m_ev[b] & ~clr) | rise;
            m_lv[b] = nb;
        end
        m_irq = p;
    endtask

    // one clock: drive, advance model at the edge, compare irq at falling edge
    task automatic step(input logic [63:0] in, input logic we,
                        input logic [11:0] a, input logic [31:0] d);
        irq_in = in; wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 1'b0;
        check({31'b0, irq_out}, {31'b0, m_irq}, "R10 irq_out vs model");
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] exp, input string tag);
        addr = a; wr_en = 1'b0;
        #1;
        check(rdata, exp, tag);
    endtask

    task automatic rd_model(input logic [11:0] a);
        addr = a; wr_en = 1'b0;
        #1;
        check(rdata, model_read(a), "R3 random read vs model");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [11:0] ADDRS [10] = '{12'h010, 12'h014, 12'h018, 12'h01C,
                                          12'h020, 12'h024, 12'h028, 12'h02C,
                                          12'h034, 12'h008};

    initial begin
        logic [63:0] cur;
        void'($urandom(32'd7));
        for (int b = 0; b < 2; b++) begin m_ev[b] = 0; m_mk[b] = 0; m_lv[b] = 0; end
        m_irq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check({31'b0, irq_out}, 32'h0, "R1 irq_out after reset");
        rd_exp(12'h010, 0, "R1 bank0 events");
        rd_exp(12'h014, 0, "R1 bank0 mask");
        rd_exp(12'h01C, 0, "R1 bank0 levels");
        rd_exp(12'h020, 0, "R1 bank1 events");
        rd_exp(12'h024, 0, "R1 bank1 mask");
        rd_exp(12'h02C, 0, "R1 bank1 levels");

        // R4 R5 R6 input 32 -> bank0 bit0
        step(64'h1_0000_0000, 0, 12'h0, 0);
        rd_exp(12'h010, 32'h1, "R4 R6 input32 event in bank0");
        rd_exp(12'h01C, 32'h1, "R5 input32 level in bank0");
        rd_exp(12'h020, 32'h0, "R4 bank1 untouched by input32");

        // R10 mask write: irq two edges later
        step(64'h1_0000_0000, 1, 12'h014, 32'h1);
        check({31'b0, irq_out}, 32'h0, "R10 irq still low right after mask edge");
        step(64'h1_0000_0000, 0, 12'h0, 0);
        check({31'b0, irq_out}, 32'h1, "R10 irq high one edge after mask");

        // R8 clear while line high, R6 no relatch while held
        step(64'h1_0000_0000, 1, 12'h018, 32'h1);
        rd_exp(12'h010, 32'h0, "R8 clear removes edge event");
        step(64'h1_0000_0000, 0, 12'h0, 0);
        rd_exp(12'h010, 32'h0, "R6 held line does not relatch");
        check({31'b0, irq_out}, 32'h0, "R10 irq low after clear");

        // R6 event survives deassert
        step(64'h0, 0, 12'h0, 0);
        step(64'h1_0000_0000, 0, 12'h0, 0);
        step(64'h0, 0, 12'h0, 0);
        rd_exp(12'h010, 32'h1, "R6 event sticky after deassert");
        rd_exp(12'h01C, 32'h0, "R5 level follows deassert");

        // R7 level-mode input 20 -> bank1 bit20
        step(64'h0010_0000, 0, 12'h0, 0);
        rd_exp(12'h020, 32'h0, "R7 level-mode bit sets no event");
        rd_exp(12'h02C, 32'h0010_0000, "R4 R5 input20 level in bank1");
        step(64'h0010_0000, 1, 12'h024, 32'h0010_0000);
        step(64'h0010_0000, 1, 12'h028, 32'hFFFF_FFFF);
        step(64'h0010_0000, 0, 12'h0, 0);
        check({31'b0, irq_out}, 32'h1, "R8 clear cannot drop level-mode request");
        step(64'h0, 0, 12'h0, 0);
        step(64'h0, 0, 12'h0, 0);
        rd_exp(12'h010, 32'h1, "R8 bank1 clear left bank0 event");

        // R9 edge and clear together
        step(64'h1_0000_0000, 1, 12'h018, 32'hFFFF_FFFF);
        rd_exp(12'h010, 32'h1, "R9 new edge wins over clear");

        // R2 R3 invalid index and offsets
        step(64'h1_0000_0000, 1, 12'h034, 32'hFFFF_FFFF);
        step(64'h1_0000_0000, 1, 12'h008, 32'hFFFF_FFFF);
        rd_exp(12'h014, 32'h1, "R2 bank0 mask kept after invalid write");
        rd_exp(12'h024, 32'h0010_0000, "R2 bank1 mask kept after invalid write");
        rd_exp(12'h010, 32'h1, "R2 event kept after invalid clear");
        rd_exp(12'h034, 32'h0, "R2 index 2 reads zero");
        rd_exp(12'h000, 32'h0, "R2 below window reads zero");
        rd_exp(12'h018, 32'h0, "R3 clear port reads zero");
        rd_exp(12'h011, 32'h0, "R3 odd offset reads zero");
        step(64'h1_0000_0000, 1, 12'h01C, 32'hFFFF_FFFF);
        rd_exp(12'h01C, 32'h1, "R3 levels write ignored");
        rd_exp(12'h014, 32'h1, "R3 mask unchanged by levels write");

        // random phase
        cur = '0;
        for (int i = 0; i < 600; i++) begin
            logic [63:0] flip;
            logic [11:0] a;
            flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            cur  = cur ^ flip;
            a    = ADDRS[$urandom % 10];
            step(cur, ($urandom % 3) == 0, a, $urandom | ({$urandom} & 32'h0010_0000));
            rd_model(ADDRS[$urandom % 10]);
        end

        finish_run();
    end

endmodule